// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a bitstream into a downstream programmable device over a slave-serial configuration port. A single start strobe launches a fixed sequence. The program pin is held high for a short settle window and then driven low so that the target's logic is disabled. The sequencer waits for the target's init pin to fall, releases program, and waits for init to rise again. It then pulls image bytes from a valid/ready byte stream and shifts them out on a data pin, driven against a clock that the block generates. Finally it waits for the target's done pin to go high.

Each of the three waits has its own timeout, given in clock cycles. A 2-bit result code reports which wait ran out. The code is 0 after a clean load, 1 when init never fell, 2 when init never rose, and 3 when done never rose. The code and a success flag hold until the next accepted start. While busy, the block ignores new start strobes.

The state machine has six states. `S_IDLE` goes to `S_PRG_HIGH` on start. `S_PRG_HIGH` goes to `S_PRG_LOW` when its settle count expires. `S_PRG_LOW` goes to `S_WAIT_INIT_HI` when init falls, or back to `S_IDLE` with code 1 on timeout. `S_WAIT_INIT_HI` goes to `S_SHIFT` when init rises, or straight to `S_WAIT_DONE` for a zero-length image, or back to `S_IDLE` with code 2 on timeout. `S_SHIFT` goes to `S_WAIT_DONE` after the last bit. `S_WAIT_DONE` goes to `S_IDLE` with success when done is high, or with code 3 on timeout.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, program is high, the configuration clock is low, and busy, success and the result code are all 0.
- R2: On an accepted start, busy rises and program stays high for exactly PRG_HIGH_CYC cycles before it is driven low.
- R3: If init stays high for T_INIT_LOW cycles while program is low, the run ends with result code 1 and success 0.
- R4: If init stays low for T_INIT_HIGH cycles after program is released, the run ends with result code 2 and success 0.
- R5: If done stays low for T_DONE cycles after the last bit, the run ends with result code 3 and success 0.
- R6: Each image byte is sent most significant bit first, one bit per configuration clock rising edge. Data never changes in the cycle the clock rises. Each clock high level lasts exactly HALF_CYC cycles, and each low level lasts at least HALF_CYC cycles.
- R7: When done is seen high in the final wait, the run ends with success 1, result code 0 and busy 0, after exactly img_len_i bytes have been clocked out.
- R8: The result code and success flag hold their values while idle and are cleared in the cycle after the next start is accepted.
- R9: A start strobe while busy has no effect: the running load keeps its captured length and completes normally.
- R10: A zero-length image skips shifting: no configuration clock edge is produced and the block goes straight to the final wait.
- R11: A byte is taken only in a cycle where valid and ready are both high. Gaps in valid lose no byte and duplicate none. Ready is never high while the configuration clock is high.
- R12: Program is high in every state except the program-low wait, including after any failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| img_len_i | input | LEN_W | Image length in bytes, captured at start |
| byte_data_i | input | 8 | Image byte |
| byte_valid_i | input | 1 | Image byte valid |
| byte_ready_o | output | 1 | Block can take an image byte |
| init_i | input | 1 | Level of the target's init pin |
| done_i | input | 1 | Level of the target's done pin |
| prog_n_o | output | 1 | Active-low program pin |
| cclk_o | output | 1 | Generated configuration clock |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Last load finished successfully |
| err_o | output | 2 | Result code: 0 ok, 1 init not low, 2 init not high, 3 done not high |

## Verification
On every cycle, the assertions check the following:
- Program falls only out of the settle state.
- The result code and success flag stay steady while idle.
- Success never appears with a nonzero code.
- A start seen while busy leaves the captured length untouched.
- Data is steady at each clock rise.
- Ready stays low while the clock is high.
- A fall of init, or a zero-length image, takes the documented transition.

Only the bench's scenarios can show the rest:
- Each timeout code, driven by a target model that withholds a particular pin response.
- MSB-first order and byte count, checked against a captured image under a steady stream and under a stalling stream.
- The exact settle length.
- That a result survives idle time and clears on the next start.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRG_HIGH,
        S_PRG_LOW,
        S_WAIT_INIT_HI,
        S_SHIFT,
        S_WAIT_DONE
    } cfg_state_e;

    typedef enum logic [1:0] {
        RES_OK          = 2'd0,
        RES_INIT_NO_LOW = 2'd1,
        RES_INIT_NO_HI  = 2'd2,
        RES_DONE_NO_HI  = 2'd3
    } cfg_result_e;

endpackage

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] reload_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);

    // Support for R3/R4/R5: an expired window stays expired until reloaded
    a_r5_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && expired_o) |=> expired_o);

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
    parameter int LEN_W    = 16,
    parameter int HALF_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             cclk_o,
    output logic             din_o,
    output logic             last_o
);

    localparam int HALF_W = $clog2(HALF_CYC) + 1;

    logic             active_q;
    logic             have_q;
    logic             cclk_q;
    logic             last_q;
    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic [LEN_W-1:0] left_q;
    logic [HALF_W-1:0] hcnt_q;

    assign byte_ready_o = active_q && !have_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            have_q   <= 1'b0;
            cclk_q   <= 1'b0;
            last_q   <= 1'b0;
            sh_q     <= '0;
            bit_q    <= '0;
            left_q   <= '0;
            hcnt_q   <= '0;
        end else begin
            last_q <= 1'b0;
            if (go_i) begin
                active_q <= (len_i != '0);
                left_q   <= len_i;
                have_q   <= 1'b0;
                cclk_q   <= 1'b0;
            end else if (active_q) begin
                if (!have_q) begin
                    if (byte_valid_i) begin
                        sh_q   <= byte_data_i;
                        have_q <= 1'b1;
                        bit_q  <= 3'd7;
                        hcnt_q <= HALF_W'(HALF_CYC - 1);
                        cclk_q <= 1'b0;
                    end
                end else if (hcnt_q != '0) begin
                    hcnt_q <= hcnt_q - HALF_W'(1);
                end else if (!cclk_q) begin
                    cclk_q <= 1'b1;
                    hcnt_q <= HALF_W'(HALF_CYC - 1);
                end else begin
                    cclk_q <= 1'b0;
                    hcnt_q <= HALF_W'(HALF_CYC - 1);
                    if (bit_q == 3'd0) begin
                        have_q <= 1'b0;
                        left_q <= left_q - LEN_W'(1);
                        if (left_q == LEN_W'(1)) begin
                            active_q <= 1'b0;
                            last_q   <= 1'b1;
                        end
                    end else begin
                        sh_q  <= {sh_q[6:0], 1'b0};
                        bit_q <= bit_q - 3'd1;
                    end
                end
            end
        end
    end

    assign cclk_o = cclk_q;
    assign din_o  = sh_q[7];
    assign last_o = last_q;

    // R6: data is set up before the rising clock edge, never changed with it
    a_r6_din_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_q) |-> $stable(sh_q[7]));

    // R11: a byte is never requested while the clock is high
    a_r11_ready_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> !cclk_q);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int HALF_CYC     = 2,
    parameter int PRG_HIGH_CYC = 3,
    parameter int T_INIT_LOW   = 20,
    parameter int T_INIT_HIGH  = 20,
    parameter int T_DONE       = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] img_len_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    input  logic             init_i,
    input  logic             done_i,
    output logic             prog_n_o,
    output logic             cclk_o,
    output logic             din_o,
    output logic             busy_o,
    output logic             ok_o,
    output logic [1:0]       err_o
);

    localparam int T_MAX_A = (T_INIT_LOW > T_INIT_HIGH) ? T_INIT_LOW : T_INIT_HIGH;
    localparam int T_MAX_B = (T_DONE > PRG_HIGH_CYC) ? T_DONE : PRG_HIGH_CYC;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int TMR_W   = $clog2(T_MAX + 1);

    cfg_state_e        state_q, state_n;
    logic [LEN_W-1:0]  len_q;
    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_reload;
    logic              shift_go, shift_last;
    logic              run_fail, run_pass;
    cfg_result_e       fail_code;
    logic [1:0]        err_q;
    logic              ok_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next state and per-phase verdict
    always_comb begin
        state_n   = state_q;
        run_fail  = 1'b0;
        run_pass  = 1'b0;
        fail_code = RES_OK;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_n = S_PRG_HIGH;
            end
            S_PRG_HIGH: begin
                if (tmr_exp) state_n = S_PRG_LOW;
            end
            S_PRG_LOW: begin
                if (!init_i) begin
                    state_n = S_WAIT_INIT_HI;
                end else if (tmr_exp) begin
                    state_n   = S_IDLE;
                    run_fail  = 1'b1;
                    fail_code = RES_INIT_NO_LOW;
                end
            end
            S_WAIT_INIT_HI: begin
                if (init_i) begin
                    state_n = (len_q == '0) ? S_WAIT_DONE : S_SHIFT;
                end else if (tmr_exp) begin
                    state_n   = S_IDLE;
                    run_fail  = 1'b1;
                    fail_code = RES_INIT_NO_HI;
                end
            end
            S_SHIFT: begin
                if (shift_last) state_n = S_WAIT_DONE;
            end
            S_WAIT_DONE: begin
                if (done_i) begin
                    state_n  = S_IDLE;
                    run_pass = 1'b1;
                end else if (tmr_exp) begin
                    state_n   = S_IDLE;
                    run_fail  = 1'b1;
                    fail_code = RES_DONE_NO_HI;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // Timer reload for the phase being entered
    always_comb begin
        tmr_load = (state_n != state_q);
        unique case (state_n)
            S_PRG_HIGH:     tmr_reload = TMR_W'(PRG_HIGH_CYC - 1);
            S_PRG_LOW:      tmr_reload = TMR_W'(T_INIT_LOW - 1);
            S_WAIT_INIT_HI: tmr_reload = TMR_W'(T_INIT_HIGH - 1);
            S_WAIT_DONE:    tmr_reload = TMR_W'(T_DONE - 1);
            default:        tmr_reload = '0;
        endcase
    end

    assign shift_go = (state_n == S_SHIFT) && (state_q != S_SHIFT);

    // Registered results and captured length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            err_q <= RES_OK;
            ok_q  <= 1'b0;
        end else if (state_q == S_IDLE && start_i) begin
            len_q <= img_len_i;
            err_q <= RES_OK;
            ok_q  <= 1'b0;
        end else if (run_fail) begin
            err_q <= fail_code;
        end else if (run_pass) begin
            ok_q  <= 1'b1;
        end
    end

    // Pin and status outputs
    always_comb begin
        prog_n_o = (state_q != S_PRG_LOW);
        busy_o   = (state_q != S_IDLE);
        ok_o     = ok_q;
        err_o    = err_q;
    end

    cfg_phase_timer #(.W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .reload_i  (tmr_reload),
        .expired_o (tmr_exp)
    );

    cfg_bit_shifter #(.LEN_W(LEN_W), .HALF_CYC(HALF_CYC)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (shift_go),
        .len_i        (len_q),
        .byte_data_i  (byte_data_i),
        .byte_valid_i (byte_valid_i),
        .byte_ready_o (byte_ready_o),
        .cclk_o       (cclk_o),
        .din_o        (din_o),
        .last_o       (shift_last)
    );

    // R2: program only falls out of the settle phase
    a_r2_prog_falls_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n_o) |-> ($past(state_q) == S_PRG_HIGH));

    // R8: results are steady while idle without a start
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start_i) |=> ($stable(err_o) && $stable(ok_o)));

    // R7: success never comes with an error code
    a_r7_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (err_o == RES_OK));

    // R9: a start while busy leaves the captured length alone
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(len_q));

    // R3: an init fall during the program-low wait moves on to the release phase
    a_r3_init_low_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PRG_LOW && !init_i) |=> (state_q == S_WAIT_INIT_HI && prog_n_o));

    // R10: a zero-length image skips the shift phase
    a_r10_zero_len_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_INIT_HI && init_i && len_q == '0) |=> (state_q == S_WAIT_DONE));

endmodule

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;

    localparam int CLK_PERIOD   = 10;
    localparam int LEN_W        = 16;
    localparam int HALF_CYC     = 2;
    localparam int PRG_HIGH_CYC = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] img_len_i = '0;
    logic [7:0]       byte_data_i;
    logic             byte_valid_i;
    logic             byte_ready_o;
    logic             init_i;
    logic             done_i;
    logic             prog_n_o, cclk_o, din_o, busy_o, ok_o;
    logic [1:0]       err_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Image source
    logic [7:0] img [16];
    int   src_idx = 0;
    int   src_len = 0;
    logic stall = 1'b0;

    // Target model controls: 0 normal, 1 init stays high, 2 init stays low, 3 done withheld
    int fail_mode = 0;
    int lo_cnt = 0;
    int hi_cnt = 0;
    int exp_bits = 0;
    int bits_seen = 0;
    logic [7:0] cap [16];

    // R6 timing monitor
    logic mon_lvl = 1'b0;
    int   mon_run = 0;
    int   mon_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_serial_loader #(
        .LEN_W(LEN_W), .HALF_CYC(HALF_CYC), .PRG_HIGH_CYC(PRG_HIGH_CYC),
        .T_INIT_LOW(20), .T_INIT_HIGH(20), .T_DONE(40)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .img_len_i(img_len_i),
        .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
        .init_i(init_i), .done_i(done_i), .prog_n_o(prog_n_o), .cclk_o(cclk_o),
        .din_o(din_o), .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o)
    );

    assign byte_valid_i = (src_idx < src_len) && !(stall && cyc[0]);
    assign byte_data_i  = img[src_idx % 16];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (byte_valid_i && byte_ready_o) src_idx <= src_idx + 1;
    end

    // Target device model
    always @(posedge clk) begin
        if (!rst_n) begin
            init_i <= 1'b1;
            done_i <= 1'b0;
        end else if (!prog_n_o) begin
            done_i <= 1'b0;
            hi_cnt = 0;
            lo_cnt = lo_cnt + 1;
            if (lo_cnt >= 4 && fail_mode != 1) init_i <= 1'b0;
        end else begin
            lo_cnt = 0;
            if (!init_i) begin
                hi_cnt = hi_cnt + 1;
                if (hi_cnt >= 4 && fail_mode != 2) init_i <= 1'b1;
            end else if (busy_o && bits_seen == exp_bits && fail_mode != 3) begin
                done_i <= 1'b1;
            end
        end
    end

    always @(posedge cclk_o) begin
        if (bits_seen < 128) cap[bits_seen / 8] = {cap[bits_seen / 8][6:0], din_o};
        bits_seen = bits_seen + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (cclk_o == mon_lvl) begin
                mon_run = mon_run + 1;
            end else begin
                if (mon_lvl && mon_run != HALF_CYC) mon_bad = mon_bad + 1;
                if (!mon_lvl && mon_run < HALF_CYC) mon_bad = mon_bad + 1;
                mon_lvl = cclk_o;
                mon_run = 1;
            end
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(!busy_o, req, int'(busy_o), 0);
    endtask

    task automatic prep(input int len, input int mode, input bit stl, input int seed);
        @(negedge clk);
        for (int i = 0; i < 16; i++) img[i] = 8'((i * 37 + seed * 11 + 8'h5A) & 8'hFF);
        for (int i = 0; i < 16; i++) cap[i] = '0;
        src_idx   = 0;
        src_len   = len;
        stall     = stl;
        fail_mode = mode;
        exp_bits  = len * 8;
        bits_seen = 0;
        img_len_i = LEN_W'(len);
    endtask

    task automatic check_image(input int len, input string req);
        int bad = 0;
        for (int i = 0; i < len; i++) if (cap[i] != img[i]) bad++;
        check(bad == 0, req, bad, 0);
        check(bits_seen == len * 8, req, bits_seen, len * 8);
    endtask

    task automatic t_reset();
        check(prog_n_o == 1'b1 && cclk_o == 1'b0, "R1", int'({prog_n_o, cclk_o}), 2);
        check(!busy_o && !ok_o && err_o == 2'd0, "R1", int'({busy_o, ok_o, err_o}), 0);
    endtask

    // R2 settle length, R6 bit order and R7 success
    task automatic t_basic();
        int n = 0;
        prep(4, 0, 1'b0, 1);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R2", int'(busy_o), 1);
        while (prog_n_o && n < 50) begin
            n++;
            @(negedge clk);
        end
        check(n == PRG_HIGH_CYC, "R2", n, PRG_HIGH_CYC);
        wait_idle("R7");
        check(ok_o && err_o == 2'd0, "R7", int'({ok_o, err_o}), 4);
        check_image(4, "R6");
        check(prog_n_o, "R12", int'(prog_n_o), 1);
    endtask

    // R11 stalled stream
    task automatic t_stall();
        prep(6, 0, 1'b1, 2);
        pulse_start();
        wait_idle("R11");
        check(ok_o, "R11", int'(ok_o), 1);
        check_image(6, "R11");
        check(src_idx == 6, "R11", src_idx, 6);
    endtask

    task automatic t_fail(input int mode, input string req);
        prep(3, mode, 1'b0, 3);
        pulse_start();
        wait_idle(req);
        check(err_o == 2'(mode) && !ok_o, req, int'(err_o), mode);
        check(prog_n_o, "R12", int'(prog_n_o), 1);
        if (mode != 3) check(bits_seen == 0, req, bits_seen, 0);
        else check(bits_seen == 24, req, bits_seen, 24);
    endtask

    // R8 hold then clear
    task automatic t_hold();
        prep(2, 3, 1'b0, 4);
        pulse_start();
        wait_idle("R8");
        repeat (30) @(negedge clk);
        check(err_o == 2'd3, "R8", int'(err_o), 3);
        prep(2, 0, 1'b0, 5);
        pulse_start();
        check(err_o == 2'd0 && busy_o, "R8", int'(err_o), 0);
        wait_idle("R8");
        check(ok_o && err_o == 2'd0, "R8", int'({ok_o, err_o}), 4);
    endtask

    // R9 start while busy
    task automatic t_busy_start();
        int n = 0;
        prep(3, 0, 1'b0, 6);
        pulse_start();
        while (!cclk_o && n < 500) begin
            @(negedge clk);
            n++;
        end
        img_len_i = LEN_W'(9);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle("R9");
        check(ok_o, "R9", int'(ok_o), 1);
        check_image(3, "R9");
    endtask

    // R10 zero length
    task automatic t_zero();
        prep(0, 0, 1'b0, 7);
        pulse_start();
        wait_idle("R10");
        check(ok_o && err_o == 2'd0, "R10", int'({ok_o, err_o}), 4);
        check(bits_seen == 0, "R10", bits_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stall();
        t_fail(1, "R3");
        t_fail(2, "R4");
        t_fail(3, "R5");
        t_hold();
        t_busy_start();
        t_zero();
        check(mon_bad == 0, "R6", mon_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule